// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a software-interrupt command word, written by one of several CPUs, into pending bits. Each write names a destination mode, an optional CPU target mask and a 4-bit interrupt number. The block works out which CPUs are targets and sets that interrupt's pending bit for each of them. Every CPU owns a bank of pending bits, one per interrupt number. When source tracking is enabled, the bank also keeps a separate bit for each sending CPU.

Each CPU retires its own pending bits through a clear strobe. The strobe carries an interrupt number and, with source tracking on, the source to retire. Prioritisation, acknowledge sequencing and the register bus sit outside this block. The block sees only a write strobe, the requester index and the 32-bit command word.

Top module: `sgi_dispatch`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every bit of `pend_o` and `pend_src_o` is 0.
- R2: A write with mode `wr_cmd[25:24]`=0 sets bit `wr_cmd[3:0]` for every CPU t whose mask bit `wr_cmd[16+t]` is 1. The result is visible on the outputs one clock edge after the write.
- R3: A write with mode 1 sets the bit for every CPU except `wr_cpu`, whatever the mask holds.
- R4: A write with mode 2 sets the bit for CPU `wr_cpu` only, whatever the mask holds.
- R5: A write with mode 3, or with mode 0 and an empty mask, changes no pending bit.
- R6: Mask bits `wr_cmd[16+t]` with t >= NUM_CPU are ignored. Command bits [15:4], [23:16+NUM_CPU] and [31:26] have no effect.
- R7: With TRACK_SRC=1, the pending state for target t, number i and source s is `pend_src_o[(t*16+i)*NUM_CPU+s]`. `pend_o[t*16+i]` is the OR of that state over all sources.
- R8: Repeated sets of one bit before any clear merge into one bit, and a single clear retires it.
- R9: `clr_en[t]` clears, one edge later, only the bit of target t with number `clr_id[4t+:4]` and source `clr_src[CPU_W*t+:CPU_W]`. All other bits keep their values.
- R10: A set and a clear of the same bit in the same cycle leave that bit set.
- R11: With `wr_en` low, no bit goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_cpu | input | CPU_W | Index of the requesting CPU (assumed < NUM_CPU) |
| wr_cmd | input | 32 | Command word: mode [25:24], mask [16+:NUM_CPU], number [3:0] |
| clr_en | input | NUM_CPU | Per-CPU clear strobe |
| clr_id | input | 4*NUM_CPU | Per-CPU interrupt number to clear |
| clr_src | input | CPU_W*NUM_CPU | Per-CPU source to clear (used with TRACK_SRC=1) |
| pend_o | output | 16*NUM_CPU | Pending bits per target and number, merged over sources |
| pend_src_o | output | 16*NUM_CPU*NUM_CPU | Pending bits per target, number and source |

## Verification
The pending flops feed the outputs directly, so any wrongly set or lost bit appears at `pend_src_o` on the clock edge right after the cause. A per-cycle reference comparison therefore catches it in the same cycle. A misdecoded mode shows up as a bit landing in a bank next to the intended one; the source-ordering checks separate this case from a wrong number field. A wrong priority between clear and set shows up only when both hit one bit in one cycle, so that collision is driven explicitly.

// File: rtl/sgi_pkg.sv
// Shared definitions for the software-generated interrupt dispatcher.
// Assumes a 32-bit command word with fixed field positions.
package sgi_pkg;
    localparam int ID_W     = 4;
    localparam int NUM_ID   = 1 << ID_W;
    localparam int MODE_LSB = 24;
    localparam int MASK_LSB = 16;

    typedef enum logic [1:0] {
        DST_LIST   = 2'd0,
        DST_OTHERS = 2'd1,
        DST_SELF   = 2'd2,
        DST_RSVD   = 2'd3
    } sgi_dst_e;
endpackage

// File: rtl/sgi_decode.sv
// Command decoder: turns a command word and the requester index into a
// per-CPU target vector and an interrupt number.
// Assumes wr_cpu < NUM_CPU and NUM_CPU <= 8. Purely combinational.
module sgi_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic               wr_en,
    input  logic [CPU_W-1:0]   wr_cpu,
    input  logic [31:0]        wr_cmd,
    output logic [NUM_CPU-1:0] tgt,
    output logic [ID_W-1:0]    id
);
    logic [NUM_CPU-1:0] self_oh;
    logic [NUM_CPU-1:0] mask;
    sgi_dst_e           mode;

    // One-hot of the requesting CPU.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_self
        assign self_oh[c] = (wr_cpu == CPU_W'(c));
    end

    assign mask = wr_cmd[MASK_LSB +: NUM_CPU];
    assign mode = sgi_dst_e'(wr_cmd[MODE_LSB +: 2]);
    assign id   = wr_cmd[ID_W-1:0];

    // Select the target set by destination mode.
    always_comb begin
        tgt = '0;
        if (wr_en) begin
            case (mode)
                DST_LIST:   tgt = mask;
                DST_OTHERS: tgt = ~self_oh;
                DST_SELF:   tgt = self_oh;
                default:    tgt = '0;
            endcase
        end
    end
endmodule

// File: rtl/sgi_bank.sv
// Pending bank of one target CPU: one bit per interrupt number, and per
// source when TRACK_SRC is set. Set wins over a clear of the same bit.
// Without source tracking each number's bit is shown in every source slot.
module sgi_bank
    import sgi_pkg::*;
#(
    parameter int NUM_CPU   = 4,
    parameter int CPU_W     = 2,
    parameter bit TRACK_SRC = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [ID_W-1:0]             set_id,
    input  logic [CPU_W-1:0]            set_src,
    input  logic                        clr_en,
    input  logic [ID_W-1:0]             clr_id,
    input  logic [CPU_W-1:0]            clr_src,
    output logic [NUM_ID-1:0]           pend_any,
    output logic [NUM_ID*NUM_CPU-1:0]   pend_src
);
    if (TRACK_SRC) begin : g_track
        logic [NUM_ID*NUM_CPU-1:0] q;
        logic [NUM_ID*NUM_CPU-1:0] set_hit;
        logic [NUM_ID*NUM_CPU-1:0] clr_hit;

        for (genvar i = 0; i < NUM_ID; i++) begin : g_id
            for (genvar s = 0; s < NUM_CPU; s++) begin : g_src
                assign set_hit[i*NUM_CPU+s] = set_en && (set_id == ID_W'(i))
                                              && (set_src == CPU_W'(s));
                assign clr_hit[i*NUM_CPU+s] = clr_en && (clr_id == ID_W'(i))
                                              && (clr_src == CPU_W'(s));
            end
            // Merge sources for the number's summary bit.
            assign pend_any[i] = |q[i*NUM_CPU +: NUM_CPU];
        end

        // Update per-source bits; set takes priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= set_hit | (q & ~clr_hit);
        end

        assign pend_src = q;
    end else begin : g_merge
        logic [NUM_ID-1:0] q;
        logic [NUM_ID-1:0] set_hit;
        logic [NUM_ID-1:0] clr_hit;

        for (genvar i = 0; i < NUM_ID; i++) begin : g_id
            assign set_hit[i] = set_en && (set_id == ID_W'(i));
            assign clr_hit[i] = clr_en && (clr_id == ID_W'(i));
            assign pend_src[i*NUM_CPU +: NUM_CPU] = {NUM_CPU{q[i]}};
        end

        // Update merged bits; set takes priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= set_hit | (q & ~clr_hit);
        end

        assign pend_any = q;

        // Source inputs are unused when sources are merged.
        logic unused_src;
        assign unused_src = ^{set_src, clr_src};
    end
endmodule

// File: rtl/sgi_dispatch.sv
// Top of the software-generated interrupt dispatcher: decodes a command
// write and drives one pending bank per target CPU.
// Assumes wr_cpu < NUM_CPU and NUM_CPU in 1..8. Synchronous active-low reset.
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int  NUM_CPU   = 4,
    parameter bit  TRACK_SRC = 1'b1,
    localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [CPU_W-1:0]                  wr_cpu,
    input  logic [31:0]                       wr_cmd,
    input  logic [NUM_CPU-1:0]                clr_en,
    input  logic [ID_W*NUM_CPU-1:0]           clr_id,
    input  logic [CPU_W*NUM_CPU-1:0]          clr_src,
    output logic [NUM_ID*NUM_CPU-1:0]         pend_o,
    output logic [NUM_ID*NUM_CPU*NUM_CPU-1:0] pend_src_o
);
    localparam int BANK_W = NUM_ID * NUM_CPU;

    logic [NUM_CPU-1:0] tgt;
    logic [ID_W-1:0]    set_id;

    // Decode the command into targets and number.
    sgi_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_decode (
        .wr_en  (wr_en),
        .wr_cpu (wr_cpu),
        .wr_cmd (wr_cmd),
        .tgt    (tgt),
        .id     (set_id)
    );

    // One pending bank per target CPU.
    for (genvar t = 0; t < NUM_CPU; t++) begin : g_bank
        sgi_bank #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .TRACK_SRC(TRACK_SRC)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (tgt[t]),
            .set_id   (set_id),
            .set_src  (wr_cpu),
            .clr_en   (clr_en[t]),
            .clr_id   (clr_id[t*ID_W +: ID_W]),
            .clr_src  (clr_src[t*CPU_W +: CPU_W]),
            .pend_any (pend_o[t*NUM_ID +: NUM_ID]),
            .pend_src (pend_src_o[t*BANK_W +: BANK_W])
        );
    end
endmodule

// File: rtl/sgi_dispatch_chk.sv
// Checker for sgi_dispatch, attached by bind. Relates command writes and
// clears at the ports to the pending outputs one edge later.
module sgi_dispatch_chk
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              wr_en,
    input logic [CPU_W-1:0]                  wr_cpu,
    input logic [31:0]                       wr_cmd,
    input logic [NUM_CPU-1:0]                clr_en,
    input logic [NUM_ID*NUM_CPU-1:0]         pend_o,
    input logic [NUM_ID*NUM_CPU*NUM_CPU-1:0] pend_src_o
);
    logic [CPU_W-1:0]         cpu_q;
    logic [NUM_ID*NUM_CPU-1:0] own_bank;

    // Remember the previous requester.
    always_ff @(posedge clk) cpu_q <= wr_cpu;

    // Bits of the previous requester's bank.
    always_comb begin
        own_bank = '0;
        for (int t = 0; t < NUM_CPU; t++)
            if (cpu_q == CPU_W'(t)) own_bank[t*NUM_ID +: NUM_ID] = '1;
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend_src_o == '0 && pend_o == '0)); // R1

    AST_RSVD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cmd[MODE_LSB +: 2] == 2'd3 && clr_en == '0)
        |=> pend_src_o == $past(pend_src_o)); // R5

    AST_NO_WRITE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (pend_src_o & ~$past(pend_src_o)) == '0); // R11

    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cmd[MODE_LSB +: 2] == 2'd2 && clr_en == '0)
        |=> ((pend_o ^ $past(pend_o)) & ~own_bank) == '0); // R4

    AST_OTHERS_SKIP_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cmd[MODE_LSB +: 2] == 2'd1 && clr_en == '0)
        |=> ((pend_o ^ $past(pend_o)) & own_bank) == '0); // R3
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_cpu     (wr_cpu),
    .wr_cmd     (wr_cmd),
    .clr_en     (clr_en),
    .pend_o     (pend_o),
    .pend_src_o (pend_src_o)
);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
    localparam int PERIOD = 10;
    localparam int NC     = 4;
    localparam int CW     = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [CW-1:0]    wr_cpu = '0;
    logic [31:0]      wr_cmd = '0;
    logic [NC-1:0]    clr_en = '0;
    logic [4*NC-1:0]  clr_id = '0;
    logic [CW*NC-1:0] clr_src = '0;
    logic [16*NC-1:0]    pend_o;
    logic [16*NC*NC-1:0] pend_src_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    bit  mdl [NC][16][NC];

    always #(PERIOD/2) clk = ~clk;

    sgi_dispatch #(.NUM_CPU(NC), .TRACK_SRC(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_cmd(wr_cmd),
        .clr_en(clr_en), .clr_id(clr_id), .clr_src(clr_src),
        .pend_o(pend_o), .pend_src_o(pend_src_o)
    );

    // Reference update from the requirements: clears first, then sets win.
    task automatic model_edge();
        bit [NC-1:0] tg;
        int          md;
        int          id;
        if (!rst_n) begin
            for (int t = 0; t < NC; t++)
                for (int i = 0; i < 16; i++)
                    for (int s = 0; s < NC; s++) mdl[t][i][s] = 1'b0;
            return;
        end
        for (int t = 0; t < NC; t++)
            if (clr_en[t]) mdl[t][clr_id[4*t +: 4]][clr_src[CW*t +: CW]] = 1'b0;
        tg = '0;
        md = int'(wr_cmd[25:24]);
        id = int'(wr_cmd[3:0]);
        if (wr_en) begin
            for (int t = 0; t < NC; t++) begin
                if (md == 0) tg[t] = wr_cmd[16+t];
                if (md == 1) tg[t] = (t != int'(wr_cpu));
                if (md == 2) tg[t] = (t == int'(wr_cpu));
            end
        end
        for (int t = 0; t < NC; t++)
            if (tg[t]) mdl[t][id][int'(wr_cpu)] = 1'b1;
    endtask

    task automatic compare(input string tag);
        logic [16*NC*NC-1:0] es;
        logic [16*NC-1:0]    ea;
        es = '0;
        ea = '0;
        for (int t = 0; t < NC; t++)
            for (int i = 0; i < 16; i++)
                for (int s = 0; s < NC; s++) begin
                    es[(t*16+i)*NC+s] = mdl[t][i][s];
                    if (mdl[t][i][s]) ea[t*16+i] = 1'b1;
                end
        n_chk++;
        if (es !== pend_src_o || ea !== pend_o) begin
            n_bad++;
            $display("FAIL %s: pend_src got %h exp %h, pend got %h exp %h",
                     tag, pend_src_o, es, pend_o, ea);
        end
    endtask

    // One cycle: drive at the falling edge, update the model at the rising
    // edge, and compare shortly after it.
    task automatic step(input bit w, input int cpu, input logic [31:0] cmd,
                        input logic [NC-1:0] ce, input logic [4*NC-1:0] ci,
                        input logic [CW*NC-1:0] cs, input string tag);
        @(negedge clk);
        wr_en   = w;
        wr_cpu  = CW'(cpu);
        wr_cmd  = cmd;
        clr_en  = ce;
        clr_id  = ci;
        clr_src = cs;
        @(posedge clk);
        model_edge();
        #1;
        compare(tag);
    endtask

    function automatic logic [31:0] cmd_of(input int md, input int msk, input int id);
        return (32'(md) << 24) | (32'(msk) << 16) | 32'(id);
    endfunction

    task automatic idle(input string tag);
        step(0, 0, 32'h0, '0, '0, '0, tag);
    endtask

    initial begin
        #(PERIOD*100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        step(0, 0, 32'h0, '0, '0, '0, "R1 in reset");
        step(0, 0, 32'h0, '0, '0, '0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 after reset");

        step(1, 0, cmd_of(0, 4'b0101, 5), '0, '0, '0, "R2 list mask 0101 id 5");
        step(1, 0, cmd_of(0, 4'b0101, 5), '0, '0, '0, "R8 repeat merges");
        step(0, 0, 32'h0, 4'b0001, 16'h0005, '0, "R8 one clear retires");
        step(0, 0, 32'h0, 4'b0100, 16'h0500, '0, "R8 clear cpu2");

        step(1, 1, cmd_of(1, 4'hF, 9), '0, '0, '0, "R3 others from cpu1");
        step(1, 3, cmd_of(2, 4'h6, 15), '0, '0, '0, "R4 self cpu3");
        step(1, 2, cmd_of(3, 4'hF, 1), '0, '0, '0, "R5 reserved mode");
        step(1, 2, cmd_of(0, 0, 1), '0, '0, '0, "R5 empty mask");
        step(1, 1, 32'h00F0_ABC3, '0, '0, '0, "R6 mask above count");
        step(1, 1, 32'hFC01_0007, '0, '0, '0, "R6 junk high bits");

        step(1, 0, cmd_of(0, 4'b1000, 4), '0, '0, '0, "R7 src0 to cpu3");
        step(1, 1, cmd_of(0, 4'b1000, 4), '0, '0, '0, "R7 src1 to cpu3");
        step(0, 0, 32'h0, 4'b1000, 16'h4000, {2'd0, 6'd0}, "R9 clear src0 only");
        step(0, 0, 32'h0, 4'b1000, 16'h4000, {2'd2, 6'd0}, "R9 clear absent src");
        step(0, 0, 32'h0, 4'b1000, 16'h4000, {2'd1, 6'd0}, "R9 clear src1");

        step(1, 2, cmd_of(0, 4'b0010, 6), '0, '0, '0, "R10 prime");
        step(1, 2, cmd_of(0, 4'b0010, 6), 4'b0010, 16'h0060, {2'd0, 2'd0, 2'd2, 2'd0},
             "R10 set beats clear");
        step(0, 0, 32'h0, 4'b0010, 16'h0060, {2'd0, 2'd0, 2'd2, 2'd0}, "R10 later clear");

        step(0, 3, cmd_of(1, 4'hF, 11), '0, '0, '0, "R11 no strobe");
        idle("R11 idle");

        for (int k = 0; k < 300; k++) begin
            logic [31:0] c;
            c = $urandom;
            step(($urandom % 3) != 0, int'($urandom % NC), c, NC'($urandom),
                 16'($urandom), 8'($urandom), "R2 R3 R4 R9 R10 random mix");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule